// File: doc/BRIEF.md
# Flash Buffered-Program Sequencer

This block programs one chunk of 32-bit words into a parallel NOR flash array built from two 16-bit devices that sit side by side on one 32-bit data bus. A client hands it a request made of an erase-block base address, the first target word address and a word count. It then feeds the data words through a valid/ready stream. The sequencer runs the whole buffered-program exchange on the flash bus by itself. First it asks for the device write buffer and polls until the buffer is granted. Then it writes the count, streams the data, confirms, and polls the status until the devices report ready.

Each command and count value goes out copied into both 16-bit halves. A status bit is taken as set only when both devices report it. Two timeouts, counted in clock cycles, guard the two polling loops. At the end the block gives a one-cycle completion pulse, an error flag, a 2-bit cause code and the captured 32-bit status word. A request that would run past the end of its erase block, that is empty, or that exceeds the chunk limit is refused without any bus activity. The flash bus is modelled as single-cycle write and read strobes, and read data is sampled in the same cycle as the read strobe.

Top module: `flash_bufprog_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. A request is refused if its count is 0, if it exceeds MAX_WORDS, or if (req_addr mod BLOCK_WORDS) + count exceeds BLOCK_WORDS. A refused request makes `done` high on the next cycle with `err`=1, `cause`=0 and `status`=0, and it causes no flash bus write or read.
- R2: An accepted request begins with a write of 0x00E800E8 (the buffer request) to the block address. This is followed by a read of the block address. The buffer counts as granted only when bit 7 and bit 23 of that read are both set.
- R3: When the buffer is not granted, the request write and the poll read are repeated. The buffer timer counts cycles from the first request write, which is cycle 0. A denied poll made at a count of TMO_CYCLES or more ends the wait: the sequencer writes 0x00700070, reads the block address once, and finishes with `err`=1, `cause`=1 and `status` set to that read.
- R4: Once the buffer is granted, the sequencer writes N-1 to the block address, with the value placed in both halves ({N-1, N-1}, 16 bits each).
- R5: The N data words are written in stream order to req_addr, req_addr+1, and so on. `wr_ready` is high only during this data phase. A stream word is written in the same cycle it is accepted, and gaps in `wr_valid` only delay the sequence.
- R6: After the last data word, 0x00D000D0 is written to the block address. The block address is then read every cycle until bit 7 and bit 23 are both set.
- R7: When ready, status bits 1, 3, 4 and 5 are checked. Any of them set in both halves gives `err`=1 and `cause`=3. Otherwise `err`=0 and `cause`=0. In both cases `status` is the final status read.
- R8: The ready wait counts cycles from the first status read, which is cycle 0. A not-ready read at a count of TMO_CYCLES or more ends the operation with `err`=1, `cause`=2 and `status` set to that read, so TMO_CYCLES+1 status reads are made.
- R9: `done` is a single-cycle pulse. `err` and `cause` are 0 whenever `done` is low. `status` changes only in a cycle where `done` is high.
- R10: `fl_we` and `fl_re` are never high together, and neither is high while the sequencer is idle.
- R11: A bit set in only one 16-bit half counts as clear. This applies both to the ready and grant bits and to the error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_blk | input | AW | Erase-block base word address |
| req_addr | input | AW | First target word address |
| req_len | input | CW | Number of words in the chunk |
| wr_valid | input | 1 | Data word offered |
| wr_ready | output | 1 | Data word can be taken |
| wr_data | input | 32 | Data word |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_rdata | input | 32 | Flash read data, valid with fl_re |
| done | output | 1 | Completion pulse |
| err | output | 1 | Operation failed (valid with done) |
| cause | output | 2 | 0 none, 1 buffer timeout, 2 ready timeout, 3 device error |
| status | output | 32 | Captured status word |

## Verification
The bench builds the sequencer with 16-bit addresses, 16-word erase blocks, an 8-word chunk limit and a 12-cycle timeout. The short timeout makes both timeout paths reachable in a few dozen cycles, so the exact number of request retries and status reads can be checked against R3 and R8. The tiny block and chunk sizes put the full-chunk-at-block-end case and all three refusal conditions within a few cycles of each other.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam int DW = 32;

  localparam logic [15:0] CMD_BUF_REQ = 16'h00E8;
  localparam logic [15:0] CMD_RD_STAT = 16'h0070;
  localparam logic [15:0] CMD_CONFIRM = 16'h00D0;

  localparam int          READY_BIT = 7;
  localparam logic [7:0]  ERR_MASK  = 8'h3A;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BUF_TMO = 2'd1,
    CAUSE_RDY_TMO = 2'd2,
    CAUSE_DEV_ERR = 2'd3
  } cause_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_POLL,
    ST_RS_CMD,
    ST_RS_RD,
    ST_COUNT,
    ST_FILL,
    ST_CONFIRM,
    ST_WAIT
  } state_e;

  function automatic logic [DW-1:0] rep16(input logic [15:0] v);
    return {v, v};
  endfunction

endpackage

// File: rtl/fbp_rst_sync.sv
module fbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fbp_timer.sv
module fbp_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1) + 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          at_lim;

  assign at_lim  = (cnt_q >= TW'(LIMIT));
  assign expired = at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && !at_lim) begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fbp_req_chk.sv
module fbp_req_chk #(
  parameter int AW          = 24,
  parameter int CW          = 9,
  parameter int BLOCK_WORDS = 65536,
  parameter int MAX_WORDS   = 256
) (
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] len,
  output logic          ok
);

  localparam int OW = $clog2(BLOCK_WORDS);

  logic [31:0] off32;
  logic [31:0] len32;

  assign off32 = 32'(addr[OW-1:0]);
  assign len32 = 32'(len);

  assign ok = (len32 != 32'd0) &&
              (len32 <= 32'(MAX_WORDS)) &&
              ((off32 + len32) <= 32'(BLOCK_WORDS));

endmodule

// File: rtl/fbp_stat_dec.sv
module fbp_stat_dec
  import fbp_pkg::*;
(
  input  logic [DW-1:0] word,
  output logic          ready,
  output logic          dev_err
);

  logic [7:0] both;

  assign both    = word[7:0] & word[23:16];
  assign ready   = both[READY_BIT];
  assign dev_err = |(both & ERR_MASK);

endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
  import fbp_pkg::*;
#(
  parameter int AW          = 24,
  parameter int BLOCK_WORDS = 65536,
  parameter int MAX_WORDS   = 256,
  parameter int TMO_CYCLES  = 250000000,
  parameter int CW          = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_blk,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [31:0]   wr_data,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [31:0]   fl_wdata,
  input  logic [31:0]   fl_rdata,
  output logic          done,
  output logic          err,
  output logic [1:0]    cause,
  output logic [31:0]   status
);

  logic rst_n_s;

  state_e        st_q, st_d;
  logic [AW-1:0] blk_q, blk_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  cause_e        cause_q, cause_d;
  logic [DW-1:0] status_q, status_d;

  logic tmr_clr, tmr_en, tmr_exp;
  logic req_ok;
  logic dec_ready, dec_err;
  logic last_word;

  fbp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fbp_timer #(.LIMIT(TMO_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .expired (tmr_exp)
  );

  fbp_req_chk #(
    .AW(AW), .CW(CW), .BLOCK_WORDS(BLOCK_WORDS), .MAX_WORDS(MAX_WORDS)
  ) u_req_chk (
    .addr (req_addr),
    .len  (req_len),
    .ok   (req_ok)
  );

  fbp_stat_dec u_stat_dec (
    .word    (fl_rdata),
    .ready   (dec_ready),
    .dev_err (dec_err)
  );

  assign last_word = (idx_q == (len_q - CW'(1)));
  assign req_ready = (st_q == ST_IDLE);

  // next-state and bus decode
  always_comb begin
    st_d     = st_q;
    blk_d    = blk_q;
    addr_d   = addr_q;
    len_d    = len_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    cause_d  = CAUSE_NONE;
    status_d = status_q;
    tmr_clr  = 1'b0;
    tmr_en   = 1'b0;
    fl_we    = 1'b0;
    fl_re    = 1'b0;
    fl_addr  = blk_q;
    fl_wdata = '0;
    wr_ready = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          blk_d   = req_blk;
          addr_d  = req_addr;
          len_d   = req_len;
          idx_d   = '0;
          tmr_clr = 1'b1;
          if (req_ok) begin
            st_d = ST_REQ;
          end else begin
            done_d   = 1'b1;
            err_d    = 1'b1;
            status_d = '0;
          end
        end
      end
      ST_REQ: begin
        fl_we    = 1'b1;
        fl_wdata = rep16(CMD_BUF_REQ);
        tmr_en   = 1'b1;
        st_d     = ST_POLL;
      end
      ST_POLL: begin
        fl_re  = 1'b1;
        tmr_en = 1'b1;
        if (dec_ready) begin
          st_d = ST_COUNT;
        end else if (tmr_exp) begin
          st_d = ST_RS_CMD;
        end else begin
          st_d = ST_REQ;
        end
      end
      ST_RS_CMD: begin
        fl_we    = 1'b1;
        fl_wdata = rep16(CMD_RD_STAT);
        st_d     = ST_RS_RD;
      end
      ST_RS_RD: begin
        fl_re    = 1'b1;
        status_d = fl_rdata;
        done_d   = 1'b1;
        err_d    = 1'b1;
        cause_d  = CAUSE_BUF_TMO;
        st_d     = ST_IDLE;
      end
      ST_COUNT: begin
        fl_we    = 1'b1;
        fl_wdata = rep16(16'(len_q - CW'(1)));
        st_d     = ST_FILL;
      end
      ST_FILL: begin
        wr_ready = 1'b1;
        fl_we    = wr_valid;
        fl_addr  = addr_q + AW'(idx_q);
        fl_wdata = wr_data;
        if (wr_valid) begin
          idx_d = idx_q + CW'(1);
          if (last_word) begin
            st_d = ST_CONFIRM;
          end
        end
      end
      ST_CONFIRM: begin
        fl_we    = 1'b1;
        fl_wdata = rep16(CMD_CONFIRM);
        tmr_clr  = 1'b1;
        st_d     = ST_WAIT;
      end
      ST_WAIT: begin
        fl_re  = 1'b1;
        tmr_en = 1'b1;
        if (dec_ready) begin
          done_d   = 1'b1;
          status_d = fl_rdata;
          if (dec_err) begin
            err_d   = 1'b1;
            cause_d = CAUSE_DEV_ERR;
          end
          st_d = ST_IDLE;
        end else if (tmr_exp) begin
          done_d   = 1'b1;
          status_d = fl_rdata;
          err_d    = 1'b1;
          cause_d  = CAUSE_RDY_TMO;
          st_d     = ST_IDLE;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q     <= ST_IDLE;
      blk_q    <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cause_q  <= CAUSE_NONE;
      status_q <= '0;
    end else begin
      st_q     <= st_d;
      blk_q    <= blk_d;
      addr_q   <= addr_d;
      len_q    <= len_d;
      idx_q    <= idx_d;
      done_q   <= done_d;
      err_q    <= err_d;
      cause_q  <= cause_d;
      status_q <= status_d;
    end
  end

  assign done   = done_q;
  assign err    = err_q;
  assign cause  = cause_q;
  assign status = status_q;

endmodule

// File: rtl/fbp_sva.sv
module fbp_sva #(
  parameter int AW = 24,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [31:0]   wr_data,
  input logic          fl_we,
  input logic          fl_re,
  input logic [31:0]   fl_wdata,
  input logic          done,
  input logic          err,
  input logic [1:0]    cause,
  input logic [31:0]   status
);

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!fl_we && !fl_re && !wr_ready)); // R10

  AST_STREAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (fl_we && fl_wdata == wr_data)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!err && cause == 2'd0)); // R9

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status)); // R9

  AST_CAUSE_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (cause == 2'd0)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R1

endmodule

bind flash_bufprog_seq fbp_sva #(.AW(AW), .CW(CW)) u_fbp_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data),
  .fl_we     (fl_we),
  .fl_re     (fl_re),
  .fl_wdata  (fl_wdata),
  .done      (done),
  .err       (err),
  .cause     (cause),
  .status    (status)
);

// File: tb/flash_bufprog_seq_bench.sv
`timescale 1ns/1ps
module flash_bufprog_seq_bench;

  localparam int AW  = 16;
  localparam int BW  = 16;
  localparam int MW  = 8;
  localparam int TMO = 12;
  localparam int CW  = $clog2(MW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_blk = '0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_len = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [31:0]   wr_data = '0;
  logic          fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [31:0]   fl_wdata;
  logic [31:0]   fl_rdata;
  logic          done, err;
  logic [1:0]    cause;
  logic [31:0]   status;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flash_bufprog_seq #(
    .AW(AW), .BLOCK_WORDS(BW), .MAX_WORDS(MW), .TMO_CYCLES(TMO)
  ) u_flash_bufprog_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .done(done), .err(err), .cause(cause), .status(status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic        mdl_load = 1'b0;
  int          cfg_deny = 0, cfg_busy = 0;
  logic [31:0] busy_stat = '0, fin_stat = '0, rs_stat = '0;
  int          phase, deny_left, busy_left, wait_reads;

  always_comb begin
    case (phase)
      1:       fl_rdata = (deny_left > 0) ? 32'h0000_0080 : 32'h0080_0080;
      2:       fl_rdata = (busy_left > 0) ? busy_stat : fin_stat;
      3:       fl_rdata = rs_stat;
      default: fl_rdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    if (mdl_load) begin
      phase      <= 0;
      deny_left  <= cfg_deny;
      busy_left  <= cfg_busy;
      wait_reads <= 0;
    end else begin
      if (fl_we) begin
        if (fl_wdata == 32'h00E8_00E8) phase <= 1;
        else if (fl_wdata == 32'h0070_0070) phase <= 3;
        else if (fl_wdata == 32'h00D0_00D0) phase <= 2;
      end
      if (fl_re) begin
        if (phase == 1 && deny_left > 0) deny_left <= deny_left - 1;
        if (phase == 2) begin
          wait_reads <= wait_reads + 1;
          if (busy_left > 0) busy_left <= busy_left - 1;
        end
      end
    end
  end

  // ---------------- expected write stream, compared every clock ----------------
  logic [AW-1:0] exp_a[$];
  logic [31:0]   exp_d[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_we && fl_re) check(1'b0, "R10", "both strobes", 32'h1, 32'h0);
      if (req_ready && (fl_we || fl_re)) check(1'b0, "R10", "bus while idle", 32'h1, 32'h0);
      if (fl_we) begin
        if (exp_d.size() == 0) begin
          check(1'b0, "R1/R2", "unexpected write", fl_wdata, 32'h0);
        end else begin
          logic [AW-1:0] ea;
          logic [31:0]   ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          check(fl_addr == ea, "R2-R6 addr", "write address", 32'(fl_addr), 32'(ea));
          check(fl_wdata == ed, "R2-R6 data", "write data", fl_wdata, ed);
        end
      end
    end
  end

  function automatic logic [31:0] dword(input int i);
    return 32'h1234_0000 + 32'(i) * 32'h0000_0101 + 32'h0000_0011;
  endfunction

  task automatic expect_op(input logic [AW-1:0] blk, input logic [AW-1:0] adr,
                           input int n, input int deny, input bit buf_tmo);
    int k;
    if (buf_tmo) begin
      k = 0;
      while ((2 * k + 1) < TMO) k++;
      for (int j = 0; j <= k; j++) begin exp_a.push_back(blk); exp_d.push_back(32'h00E8_00E8); end
      exp_a.push_back(blk); exp_d.push_back(32'h0070_0070);
    end else begin
      for (int j = 0; j <= deny; j++) begin exp_a.push_back(blk); exp_d.push_back(32'h00E8_00E8); end
      exp_a.push_back(blk); exp_d.push_back({16'(n - 1), 16'(n - 1)});
      for (int j = 0; j < n; j++) begin exp_a.push_back(adr + AW'(j)); exp_d.push_back(dword(j)); end
      exp_a.push_back(blk); exp_d.push_back(32'h00D0_00D0);
    end
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_data  = dword(i);
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      if (gaps) @(negedge clk);
    end
  endtask

  task automatic intrude();
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_blk = 16'h0070; req_addr = 16'h0070; req_len = 1;
    check(req_ready == 1'b0, "R1", "req_ready while busy", 32'(req_ready), 32'h0);
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(input string tag, input logic [AW-1:0] blk, input logic [AW-1:0] adr,
                     input int n, input int deny, input int busy,
                     input logic [31:0] bstat, input logic [31:0] fstat, input logic [31:0] rstat,
                     input bit buf_tmo, input bit gaps, input bit intr,
                     input bit e_err, input logic [1:0] e_cause, input logic [31:0] e_stat,
                     input int e_reads);
    int cyc;
    cfg_deny = deny; cfg_busy = busy;
    busy_stat = bstat; fin_stat = fstat; rs_stat = rstat;
    mdl_load = 1'b1;
    @(negedge clk);
    mdl_load = 1'b0;
    expect_op(blk, adr, n, deny, buf_tmo);
    check(req_ready == 1'b1, "R1", {tag, " ready before"}, 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_blk = blk; req_addr = adr; req_len = CW'(n);
    @(negedge clk);
    req_valid = 1'b0;
    fork
      if (!buf_tmo) feed(n, gaps);
      if (intr) intrude();
    join_none
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    check(done == 1'b1, "R9", {tag, " done seen"}, 32'(done), 32'h1);
    check(err == e_err, "R7", {tag, " err"}, 32'(err), 32'(e_err));
    check(cause == e_cause, "R7/R3/R8", {tag, " cause"}, 32'(cause), 32'(e_cause));
    check(status == e_stat, "R7", {tag, " status"}, status, e_stat);
    check(exp_d.size() == 0, "R6", {tag, " writes left"}, 32'(exp_d.size()), 32'h0);
    if (e_reads > 0)
      check(wait_reads == e_reads, "R8", {tag, " status reads"}, 32'(wait_reads), 32'(e_reads));
    @(negedge clk);
    check(done == 1'b0, "R9", {tag, " pulse width"}, 32'(done), 32'h0);
    check(err == 1'b0 && cause == 2'd0, "R9", {tag, " err cleared"}, {err, cause}, 32'h0);
    check(status == e_stat, "R9", {tag, " status held"}, status, e_stat);
    exp_a.delete(); exp_d.delete();
    wait fork;
    repeat (2) @(negedge clk);
  endtask

  task automatic reject(input string tag, input logic [AW-1:0] blk,
                        input logic [AW-1:0] adr, input int n);
    req_valid = 1'b1; req_blk = blk; req_addr = adr; req_len = CW'(n);
    @(negedge clk);
    req_valid = 1'b0;
    check(done == 1'b1 && err == 1'b1, "R1", {tag, " refused"}, {done, err}, 32'h3);
    check(cause == 2'd0 && status == 32'h0, "R1", {tag, " refuse code"}, status | 32'(cause), 32'h0);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    check(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'h1);
    check(done == 1'b0 && status == 32'h0, "R9", "reset outputs", status | 32'(done), 32'h0);
    check(!fl_we && !fl_re && !wr_ready, "R10", "reset bus", {fl_we, fl_re, wr_ready}, 32'h0);

    // R2 R4 R5 R6 R11: grant after two denials, half-ready busy status, stream gaps, intrusion
    run("normal", 16'h0040, 16'h0042, 3, 2, 3, 32'h0080_0000, 32'h0080_0080, 32'h0,
        1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0080_0080, 4);
    // R1 full chunk ending exactly at block end
    run("fullchunk", 16'h0050, 16'h0058, 8, 0, 0, 32'h0, 32'h0080_0080, 32'h0,
        1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0080_0080, 1);
    // R7 program failure in both halves
    run("progfail", 16'h0020, 16'h0023, 1, 0, 1, 32'h0, 32'h0090_0090, 32'h0,
        1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h0090_0090, 2);
    // R7 block locked in both halves
    run("locked", 16'h0030, 16'h0030, 2, 1, 0, 32'h0, 32'h0082_0082, 32'h0,
        1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 32'h0082_0082, 1);
    // R11 error bit in one half only is not an error
    run("halferr", 16'h0030, 16'h0034, 2, 0, 0, 32'h0, 32'h0080_0090, 32'h0,
        1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0080_0090, 1);
    // R8 R11 ready only in low half never counts: ready timeout after TMO+1 reads
    run("rdytmo", 16'h0010, 16'h0011, 2, 0, 1000, 32'h0000_0080, 32'h0080_0080, 32'h0,
        1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 32'h0000_0080, TMO + 1);
    // R3 buffer never granted
    run("buftmo", 16'h0060, 16'h0061, 4, 1000, 0, 32'h0, 32'h0, 32'h00B0_00B0,
        1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 32'h00B0_00B0, 0);
    // R1 refusals
    reject("zero", 16'h0040, 16'h0040, 0);
    reject("toolong", 16'h0040, 16'h0040, MW + 1);
    reject("crossing", 16'h0060, 16'h006E, 3);
    check(exp_d.size() == 0 && req_ready, "R1", "idle after refusals", 32'(req_ready), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule